// File: doc/BRIEF.md
# Prescaled Interval Timer with Wrap Interrupt

This block is a free-running 8-bit interval timer for a microcontroller peripheral bus. It does not count system clocks. It counts rising edges of one tap of an external prescaler. A 3-bit select field in its control register picks that tap from eight candidates, which run from the divide-by-16 tap up to the divide-by-2048 tap. Each time the count rolls over from its top value to zero, the block latches an interrupt request. It also emits a single-clock overflow strobe, which a watchdog can use as its count source.

The control register and the counter sit at one bus address. A write updates the control fields, and the read data always shows the live count. The control register holds three things:

- a clear bit, which zeroes the counter and then drops back to 0 by itself;
- two stored enables, for the watchdog and for the prescaler, which leave the block as output pins;
- the tap select field.

Software acknowledges the interrupt request through a dedicated input.

Top module: `interval_timer`

## Requirements
- R1: After reset, bus_rd_data is 0x00, and irq_flag, ovf_pulse, wdt_en and pscl_en are all 0. The tap select is 0.
- R2: The select field is write-data bits [2:0]. A value k makes ps_tap[k] the count source, where ps_tap[k] is prescaler tap 4+k. Edges on the other seven tap inputs do not change the count.
- R3: The counter advances by exactly one on each clock in which the selected tap is high after having been low the cycle before. A tap held high for many cycles counts once.
- R4: When the count wraps from 0xFF to 0x00, irq_flag is set from the next clock on. It stays set until irq_ack is high for a clock. If a wrap and irq_ack occur in the same clock, the wrap wins.
- R5: ovf_pulse is high for exactly one clock per wrap, in the same cycle in which the count first reads 0x00.
- R6: A bus write stores write-data bit 5 as wdt_en and bit 4 as pscl_en, and a write with bit 3 at 0 leaves the count unchanged. bus_rd_data always returns the current count.
- R7: Writing 1 to bit 3 sets the clear bit. On the following clock the counter becomes 0x00 and the clear bit returns to 0, so counting resumes afterwards. Clear takes priority over a coincident tap edge, and that edge produces no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_tap | input | 8 | Prescaler taps 4..11; bit k is tap 4+k |
| bus_wr_en | input | 1 | Write strobe for the shared address |
| bus_wr_data | input | 8 | Control write data |
| bus_rd_data | output | 8 | Live counter value |
| irq_ack | input | 1 | Clears the interrupt request flag |
| irq_flag | output | 1 | Sticky wrap interrupt request |
| ovf_pulse | output | 1 | One-clock strobe on wrap, watchdog source |
| wdt_en | output | 1 | Stored watchdog enable (bit 5) |
| pscl_en | output | 1 | Stored prescaler enable (bit 4) |

## Verification
The condition that is hardest to reach is the wrap. It needs 256 detected edges on the selected tap after a known starting count, and those edges are slow when the prescaler runs free. The bench therefore drives the tap inputs directly, one edge per two clocks. It zeroes the counter with the clear bit first and stops at 0xFF to confirm that no flag is raised early. It then gives the final edge and watches ovf_pulse on every cycle, to show that the strobe lasts exactly one clock.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned ITMR_SEL_W  = 3;
  localparam int unsigned ITMR_DATA_W = 8;

  typedef struct packed {
    logic                  wdt_en;
    logic                  pscl_en;
    logic                  clr;
    logic [ITMR_SEL_W-1:0] sel;
  } itmr_ctrl_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = ITMR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output itmr_ctrl_t        ctrl
);
  itmr_ctrl_t ctrl_d, ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.clr) ctrl_d.clr = 1'b0;
    if (wr_en) begin
      ctrl_d.wdt_en  = wr_data[5];
      ctrl_d.pscl_en = wr_data[4];
      ctrl_d.clr     = wr_data[3];
      ctrl_d.sel     = wr_data[ITMR_SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R7: clear bit lives one clock unless rewritten
  a_r7_clr_self: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clr && !wr_en) |=> !ctrl_q.clr);
  // R6: enables follow the written bits
  a_r6_enables_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q.wdt_en == $past(wr_data[5])) && (ctrl_q.pscl_en == $past(wr_data[4])));
endmodule

// File: rtl/itmr_tap_edge.sv
module itmr_tap_edge #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NTAPS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic tap_now;
  logic prev_d, prev_q;

  always_comb begin
    tap_now = taps[sel];
    prev_d  = tap_now;
    tick    = tap_now & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R3: a detected edge never repeats on the next clock
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             irq_d, irq_q;
  logic             ovf_d, ovf_q;
  logic             wrap;

  always_comb begin
    wrap  = tick & ~clr & (cnt_q == CNT_MAX);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    irq_d = wrap | (irq_q & ~irq_ack);
    ovf_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
  assign ovf = ovf_q;

  // R7: clear zeroes the count on the next clock
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !ovf_q);
  // R3: count only holds or steps by one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R5: strobe lasts one clock and coincides with a zero count
  a_r5_ovf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);
  a_r5_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0) && irq_q);
  // R4: flag holds until acknowledged
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = ITMR_DATA_W,
  localparam int unsigned NTAPS = 1 << ITMR_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAPS-1:0]  ps_tap,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic [CNT_W-1:0]  bus_rd_data,
  input  logic              irq_ack,
  output logic              irq_flag,
  output logic              ovf_pulse,
  output logic              wdt_en,
  output logic              pscl_en
);
  itmr_ctrl_t ctrl;
  logic       tick;

  itmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .wr_data (bus_wr_data),
    .ctrl    (ctrl)
  );

  itmr_tap_edge #(.SEL_W(ITMR_SEL_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (ps_tap),
    .sel   (ctrl.sel),
    .tick  (tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (ctrl.clr),
    .irq_ack (irq_ack),
    .cnt     (bus_rd_data),
    .irq     (irq_flag),
    .ovf     (ovf_pulse)
  );

  assign wdt_en  = ctrl.wdt_en;
  assign pscl_en = ctrl.pscl_en;
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ps_tap;
  logic       bus_wr_en;
  logic [7:0] bus_wr_data;
  logic [7:0] bus_rd_data;
  logic       irq_ack;
  logic       irq_flag, ovf_pulse, wdt_en, pscl_en;

  int n_tests = 0;
  int n_fail  = 0;
  int ovf_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .ps_tap(ps_tap), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .irq_ack(irq_ack),
    .irq_flag(irq_flag), .ovf_pulse(ovf_pulse), .wdt_en(wdt_en), .pscl_en(pscl_en)
  );

  always @(negedge clk) if (rst_n && ovf_pulse) ovf_seen++;

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic pulse_tap(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ps_tap[idx] = 1'b1;
      @(negedge clk); ps_tap[idx] = 1'b0;
    end
  endtask

  task automatic clear_count(input logic [2:0] sel);
    bus_write({5'b00001, sel});
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", bus_rd_data, 0);
    check("R1 irq", irq_flag, 0);
    check("R1 ovf", ovf_pulse, 0);
    check("R1 enables", {wdt_en, pscl_en}, 0);
  endtask

  task automatic t_select;
    pulse_tap(0, 5);
    check("R2 sel0 counts tap0", bus_rd_data, 5);
    pulse_tap(3, 4);
    check("R2 other tap ignored", bus_rd_data, 5);
    bus_write(8'h05);
    check("R6 write keeps count", bus_rd_data, 5);
    pulse_tap(5, 3);
    check("R2 sel5 counts tap5", bus_rd_data, 8);
    pulse_tap(0, 2);
    check("R2 tap0 ignored at sel5", bus_rd_data, 8);
  endtask

  task automatic t_level;
    @(negedge clk); ps_tap[5] = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 held tap counts once", bus_rd_data, 9);
    ps_tap[5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_enables;
    bus_write(8'h35);
    check("R6 wdt_en bit5", wdt_en, 1);
    check("R6 pscl_en bit4", pscl_en, 1);
    bus_write(8'h15);
    check("R6 wdt_en cleared", wdt_en, 0);
    check("R6 pscl_en kept", pscl_en, 1);
    check("R6 count untouched", bus_rd_data, 9);
  endtask

  task automatic t_clear;
    clear_count(3'd2);
    check("R7 clear zeroes", bus_rd_data, 0);
    check("R7 clear drops pscl_en", pscl_en, 0);
    pulse_tap(2, 3);
    check("R7 counting resumes", bus_rd_data, 3);
  endtask

  task automatic t_wrap;
    clear_count(3'd7);
    ovf_seen = 0;
    pulse_tap(7, 255);
    check("R4 no flag before wrap", irq_flag, 0);
    check("R3 count at top", bus_rd_data, 255);
    pulse_tap(7, 1);
    check("R4 flag on wrap", irq_flag, 1);
    check("R5 count zero at wrap", bus_rd_data, 0);
    repeat (3) @(negedge clk);
    check("R5 one strobe", ovf_seen, 1);
    check("R5 strobe low after", ovf_pulse, 0);
    pulse_tap(7, 2);
    check("R4 flag sticky", irq_flag, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R4 ack clears", irq_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; ps_tap = '0; bus_wr_en = 1'b0; bus_wr_data = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_select();
    t_level();
    t_enables();
    t_clear();
    t_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule